// File: doc/BRIEF.md
# Programmable Threshold Logic Gate

This block is one threshold element. Each of its eight binary inputs is first passed through a polarity mask. Each resulting bit then selects a signed integer weight. The selected weights are added, and the sum is compared with a signed threshold. The registered output is 1 when the sum reaches the threshold. Software-like loading is done over a small configuration port that addresses one weight, the threshold or the polarity mask per write.

Two rewrite commands act on the stored configuration in hardware. The first is a convert command on input j. It negates weight j, lowers the threshold by the old weight j and flips polarity bit j, so the realised function stays exactly the same while the sign of that weight changes. The second is an invert command. It negates every weight and the threshold, which yields the complement of the function. Because the comparison is inclusive, this holds only when no input pattern lands exactly on the threshold. The invert command therefore takes effect only when the caller asserts a flag vouching for that.

Top module: `thr_gate`

## Requirements
- R1: The output y is 1 exactly when the sum over i of w[i]·e[i] is at least the threshold T, and 0 otherwise. Here e[i] = x[i] XOR pol[i]. y is registered and reflects the inputs and configuration present at the previous rising clock edge.
- R2: While rst_n is low, y is 0 and all weights, the threshold and the polarity mask are cleared to 0. After release, with that cleared configuration, y is 1 for every input pattern.
- R3: A write with cfg_we=1 is addressed by cfg_sel. Values 0 to 7 load weight i from cfg_data[7:0] as 8-bit two's complement. Value 8 loads the threshold from cfg_data[11:0] as 12-bit two's complement. Value 9 loads the polarity mask from cfg_data[7:0], with bit i applying to input i. Values 10 to 15 change nothing.
- R4: Negative weights work. Weights -2 and -2 on x[0] and x[1] with threshold -1 give y = NOR(x[0], x[1]).
- R5: Weights -6, 5, -4, 2 on x[0..3] with threshold -2 give y=1 for minterms 0, 1, 3, 4, 5, 6, 7, 12 and 13 only. The minterm number is formed with x[0] as its most significant bit and x[3] as its least significant bit.
- R6: Weights 2, 4, 4, 2 on x[0..3] with threshold 4 give y = x[1] | x[2] | (x[0] & x[3]).
- R7: A convert command on index j takes one clock edge. Weight j becomes its negation, T becomes T minus the old weight j, and pol[j] toggles. The function seen at y is unchanged.
- R8: An invert command with inv_safe=1 negates every weight and the threshold in one edge. For a configuration with no tie between sum and threshold, y then gives the complement of the previous function.
- R9: An invert command with inv_safe=0 changes nothing.
- R10: When commands coincide on an edge, a convert command overrides both a configuration write and an invert command. An accepted invert command overrides a configuration write. The overridden operation is dropped entirely.
- R11: No overflow occurs at the extremes. With all weights at -128 or 127 and thresholds near the summed extremes, y follows R1, and this remains true after converts push weights to +128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| x | input | 8 | Binary data inputs |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 4 | Write target: weight index, threshold (8) or polarity mask (9) |
| cfg_data | input | 12 | Write value |
| conv_req | input | 1 | Convert command strobe |
| conv_idx | input | 3 | Input index for the convert command |
| inv_req | input | 1 | Invert command strobe |
| inv_safe | input | 1 | Caller's assurance that no pattern ties with the threshold |
| y | output | 1 | Registered threshold output |

## Verification
The interesting collisions are a convert command landing on the same edge as a configuration write, and a convert command landing on the same edge as an invert command. The bench raises both strobes in one cycle. It then sweeps every input pattern and requires the output to match the unconverted function, which shows that the write or the invert was dropped while the convert still took effect. A third collision raises an accepted invert together with a threshold write, and the bench expects the plain complement.

// File: rtl/thr_gate.sv
module thr_gate #(
  parameter int N  = 8,
  parameter int WW = 8,
  parameter int TW = 12,
  localparam int IW   = $clog2(N),
  localparam int SELW = $clog2(N + 2)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    x,
  input  logic            cfg_we,
  input  logic [SELW-1:0] cfg_sel,
  input  logic [TW-1:0]   cfg_data,
  input  logic            conv_req,
  input  logic [IW-1:0]   conv_idx,
  input  logic            inv_req,
  input  logic            inv_safe,
  output logic            y
);
  localparam int WI = WW + 1;
  localparam int AW = WI + IW + 1;
  localparam int SW = ((TW > AW) ? TW : AW) + 2;

  logic [N-1:0][WI-1:0] wt;
  logic signed [SW-1:0] thr;
  logic [N-1:0]         pol;
  logic [N-1:0]         xe;
  logic signed [SW-1:0] acc;
  logic signed [SW-1:0] wsel;
  logic                 inv_go;

  assign xe     = x ^ pol;
  assign inv_go = inv_req && inv_safe;
  assign wsel   = SW'($signed(wt[conv_idx]));

  always_comb begin
    acc = '0;
    for (int i = 0; i < N; i++)
      if (xe[i]) acc = acc + SW'($signed(wt[i]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wt  <= '0;
      thr <= '0;
      pol <= '0;
      y   <= 1'b0;
    end else begin
      y <= (acc >= thr);
      if (conv_req) begin
        wt[conv_idx]  <= WI'(-$signed(wt[conv_idx]));
        thr           <= thr - wsel;
        pol[conv_idx] <= ~pol[conv_idx];
      end else if (inv_go) begin
        for (int i = 0; i < N; i++) wt[i] <= WI'(-$signed(wt[i]));
        thr <= -thr;
      end else if (cfg_we) begin
        if (cfg_sel < SELW'(N))
          wt[cfg_sel[IW-1:0]] <= WI'($signed(cfg_data[WW-1:0]));
        else if (cfg_sel == SELW'(N))
          thr <= SW'($signed(cfg_data));
        else if (cfg_sel == SELW'(N + 1))
          pol <= cfg_data[N-1:0];
      end
    end
  end
endmodule

// File: rtl/thr_gate_chk.sv
module thr_gate_chk #(
  parameter int N  = 8,
  parameter int WW = 8,
  parameter int TW = 12,
  localparam int IW = $clog2(N),
  localparam int WI = WW + 1,
  localparam int AW = WI + IW + 1,
  localparam int SW = ((TW > AW) ? TW : AW) + 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cfg_we,
  input logic                 conv_req,
  input logic [IW-1:0]        conv_idx,
  input logic                 inv_req,
  input logic                 inv_safe,
  input logic [N-1:0][WI-1:0] wt,
  input logic signed [SW-1:0] thr,
  input logic [N-1:0]         pol
);
  logic [IW-1:0]        idx_q;
  logic signed [SW-1:0] w_q;

  always_ff @(posedge clk) begin
    idx_q <= conv_idx;
    w_q   <= SW'($signed(wt[conv_idx]));
  end

  a_r7_conv_weight: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |=> SW'($signed(wt[idx_q])) == -w_q);
  a_r7_conv_thr: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |=> thr == $past(thr) - w_q);
  a_r7_conv_pol: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |=> (pol ^ $past(pol)) == (N'(1) << idx_q));
  a_r8_inv_thr: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_req && inv_safe && !conv_req) |=> thr == -$past(thr));
  a_r9_inv_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_req && !inv_safe && !conv_req && !cfg_we) |=> $stable(thr) && $stable(pol) && $stable(wt));
  a_r10_conv_first: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && (cfg_we || inv_req)) |=> $countones(pol ^ $past(pol)) == 1 && thr == $past(thr) - w_q);
endmodule

bind thr_gate thr_gate_chk #(.N(N), .WW(WW), .TW(TW)) u_chk (.*);

// File: tb/thr_gate_tb.sv
module thr_gate_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int IW = 3;
  localparam int SELW = 4;
  localparam int TW = 12;

  logic clk = 0;
  logic rst_n = 0;
  logic [N-1:0] x = '0;
  logic cfg_we = 0;
  logic [SELW-1:0] cfg_sel = '0;
  logic [TW-1:0] cfg_data = '0;
  logic conv_req = 0;
  logic [IW-1:0] conv_idx = '0;
  logic inv_req = 0;
  logic inv_safe = 0;
  logic y;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int mw[N];
  int mt;
  logic [N-1:0] mp;

  always #(CLK_PERIOD/2) clk = ~clk;

  thr_gate u_dut (.clk(clk), .rst_n(rst_n), .x(x), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_data(cfg_data), .conv_req(conv_req), .conv_idx(conv_idx), .inv_req(inv_req),
    .inv_safe(inv_safe), .y(y));

  function automatic logic model_y(input logic [N-1:0] xv);
    int s = 0;
    for (int i = 0; i < N; i++) if (xv[i] ^ mp[i]) s += mw[i];
    return s >= mt;
  endfunction

  task automatic chk(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s x=%h actual %b expected %b", tag, x, got, exp);
    end
  endtask

  task automatic pulse(input bit cv, input int ci, input bit iv, input bit sf,
                       input bit we, input int sel, input int d);
    @(negedge clk);
    conv_req = cv; conv_idx = ci[IW-1:0]; inv_req = iv; inv_safe = sf;
    cfg_we = we; cfg_sel = sel[SELW-1:0]; cfg_data = d[TW-1:0];
    @(negedge clk);
    conv_req = 0; inv_req = 0; inv_safe = 0; cfg_we = 0;
  endtask

  task automatic wr_w(input int i, input int v); mw[i] = v; pulse(0, 0, 0, 0, 1, i, v); endtask
  task automatic wr_t(input int v); mt = v; pulse(0, 0, 0, 0, 1, N, v); endtask
  task automatic wr_p(input int m); mp = m[N-1:0]; pulse(0, 0, 0, 0, 1, N + 1, m); endtask

  task automatic put_x(input logic [N-1:0] v);
    @(negedge clk) x = v;
    @(negedge clk);
  endtask

  task automatic sweep(input string tag, input int nb);
    for (int v = 0; v < (1 << nb); v++) begin
      put_x(v[N-1:0]);
      chk(tag, y, model_y(v[N-1:0]));
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 0;
    foreach (mw[i]) mw[i] = 0;
    mt = 0; mp = '0;
    x = 8'hA5;
    repeat (3) @(negedge clk);
    chk("R2 y low in reset", y, 1'b0);
    rst_n = 1;
  endtask

  task automatic t_reset();
    do_reset();
    put_x(8'h00); chk("R2 cleared config x=00", y, 1'b1);
    put_x(8'hFF); chk("R2 cleared config x=FF", y, 1'b1);
    put_x(8'h3C); chk("R1 cleared config x=3C", y, 1'b1);
  endtask

  task automatic t_nor();
    do_reset();
    wr_w(0, -2); wr_w(1, -2); wr_t(-1);
    for (int v = 0; v < 4; v++) begin
      put_x(v[N-1:0]);
      chk("R4 NOR", y, ~(v[0] | v[1]));
    end
    put_x(8'hFC); chk("R1 unused inputs", y, 1'b1);
  endtask

  task automatic t_listed();
    do_reset();
    wr_w(0, -6); wr_w(1, 5); wr_w(2, -4); wr_w(3, 2); wr_t(-2);
    for (int m = 0; m < 16; m++) begin
      logic e;
      e = (m inside {0, 1, 3, 4, 5, 6, 7, 12, 13});
      put_x({4'b0, m[0], m[1], m[2], m[3]});
      chk("R5 minterm table", y, e);
    end
  endtask

  task automatic t_positive();
    do_reset();
    wr_w(0, 2); wr_w(1, 4); wr_w(2, 4); wr_w(3, 2); wr_t(4);
    for (int v = 0; v < 16; v++) begin
      put_x(v[N-1:0]);
      chk("R6 positive set", y, v[1] | v[2] | (v[0] & v[3]));
    end
  endtask

  task automatic t_config();
    do_reset();
    wr_w(0, -2); wr_w(1, -2); wr_t(-1);
    wr_p(8'h01);
    sweep("R3 polarity mask", 2);
    wr_w(5, 300);
    sweep("R3 weight low byte", 6);
    pulse(0, 0, 0, 0, 1, 12, 12'h7FF);
    pulse(0, 0, 0, 0, 1, 15, 12'h800);
    sweep("R3 unused select ignored", 6);
  endtask

  task automatic t_convert();
    do_reset();
    wr_w(0, -6); wr_w(1, 5); wr_w(2, -4); wr_w(3, 2); wr_t(-2);
    pulse(1, 0, 0, 0, 0, 0, 0);
    pulse(1, 2, 0, 0, 0, 0, 0);
    sweep("R7 convert keeps function", 4);
    pulse(1, 0, 0, 0, 0, 0, 0);
    sweep("R7 convert back", 4);
  endtask

  task automatic t_invert();
    do_reset();
    wr_w(0, -2); wr_w(1, -2); wr_t(-1);
    pulse(0, 0, 1, 0, 0, 0, 0);
    sweep("R9 unsafe invert ignored", 2);
    pulse(0, 0, 1, 1, 0, 0, 0);
    for (int v = 0; v < 4; v++) begin
      put_x(v[N-1:0]);
      chk("R8 invert gives OR", y, v[0] | v[1]);
    end
    do_reset();
    wr_w(0, 2); wr_w(1, 4); wr_w(2, 4); wr_w(3, 2); wr_t(5);
    pulse(0, 0, 1, 1, 0, 0, 0);
    for (int v = 0; v < 16; v++) begin
      int s;
      s = 2 * v[0] + 4 * v[1] + 4 * v[2] + 2 * v[3];
      put_x(v[N-1:0]);
      chk("R8 invert tie-free set", y, s < 5);
    end
  endtask

  task automatic t_collide();
    do_reset();
    wr_w(0, -6); wr_w(1, 5); wr_w(2, -4); wr_w(3, 2); wr_t(-2);
    pulse(1, 1, 0, 0, 1, N, 100);
    sweep("R10 convert beats write", 4);
    pulse(1, 2, 1, 1, 0, 0, 0);
    sweep("R10 convert beats invert", 4);
    do_reset();
    wr_w(0, -2); wr_w(1, -2); wr_t(-1);
    pulse(0, 0, 1, 1, 1, N, 50);
    for (int v = 0; v < 4; v++) begin
      put_x(v[N-1:0]);
      chk("R10 invert beats write", y, v[0] | v[1]);
    end
  endtask

  task automatic t_extreme();
    do_reset();
    for (int i = 0; i < N; i++) wr_w(i, -128);
    wr_t(-1023);
    sweep("R11 all -128", 8);
    for (int i = 0; i < N; i++) pulse(1, i, 0, 0, 0, 0, 0);
    sweep("R11 after converting all", 8);
    do_reset();
    for (int i = 0; i < N; i++) wr_w(i, 127);
    wr_t(1016);
    sweep("R11 all 127", 8);
  endtask

  initial begin
    t_reset();
    t_nor();
    t_listed();
    t_positive();
    t_config();
    t_convert();
    t_invert();
    t_collide();
    t_extreme();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule